// File: doc/BRIEF.md
# Serial Line Status Tracker

This block keeps the eight-bit line status word for one channel of a 16550-style serial port. The receive shifter reports each finished character together with its parity, framing and break indications. The transmit path reports bytes written by the host, bytes handed to the shift register, and whether the shift register is idle. The host's read strobes for the receive buffer, the status word and the interrupt identification register complete the picture. From these inputs the block computes the status byte, a line-status interrupt request and a transmit-empty interrupt request. It also holds the received characters and presents the oldest one as `rx_head_data`.

The block works in two modes, selected by `fifo_mode`. In single-buffer mode (`fifo_mode`=0) the receive side holds one character, and error flags stay set until the host reads the status word. In queued mode (`fifo_mode`=1) the receive side holds up to `RX_DEPTH` characters. Each stored character carries its own parity, framing and break flags, and those flags appear in the status word only once that character reaches the head of the queue.

The receive input has no back-pressure. `rx_valid` is a one-cycle event that cannot be stalled. A character that finds no room is counted as an overrun, and in queued mode it is lost. The host drains the queue with `host_rd_buf` one byte per strobe, and a strobe on an empty queue has no effect.

Top module: `uart_lsr_tracker`

## Requirements
- R1: After reset the status byte `lsr` reads 0x60, and both `rls_irq` and `thre_irq` are 0.
- R2: Bit 0 (data ready) is 1 from the cycle after a character is accepted. In single-buffer mode one `host_rd_buf` strobe clears it. In queued mode it stays 1 until the last stored character has been read.
- R3: In single-buffer mode, a character that arrives while the previous one is unread replaces it in `rx_head_data` and sets bit 1 (overrun).
- R4: In queued mode, a character that arrives while `RX_DEPTH` characters are stored (with no buffer read in that cycle) sets bit 1 and is discarded, and the stored characters are unchanged.
- R5: A `host_rd_lsr` strobe clears bits 1 to 4. If a set event (overrun, or a new error flag) occurs in the same cycle, the set wins.
- R6: In queued mode, bit 2 (parity), bit 3 (framing) and bit 4 (break) show the flags of the character at the head. A flagged character further back does not set them.
- R7: A character reported with the break flag is stored as exactly one 0x00 entry, whatever `rx_data` holds, and sets bit 4.
- R8: Bit 5 (transmit holding empty) is 1 when no written byte awaits the shifter. A byte written with `tx_load` clears it, the last `tx_to_shift` sets it, and a status read leaves it unchanged. Queued mode holds up to `TX_DEPTH` bytes.
- R9: Bit 6 (transmitter empty) is 1 only while bit 5 is 1 and `tx_shift_idle` is 1.
- R10: Bit 7 is 0 in single-buffer mode. In queued mode it is 1 while any stored character carries a parity, framing or break flag, and a status read does not clear it while such a character remains.
- R11: `rls_irq` is 1 exactly when `ier_rls_en` is 1 and any of bits 1 to 4 is 1.
- R12: `thre_irq` becomes pending when bit 5 rises, or when `ier_thre_en` rises while bit 5 is 1. It is driven only while `ier_thre_en` is 1 and bit 5 is 1. It is cleared by `host_rd_iir_thre` or by a `tx_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects queued mode, 0 selects single-buffer mode |
| ier_rls_en | input | 1 | Line-status interrupt enable |
| ier_thre_en | input | 1 | Transmit-empty interrupt enable |
| rx_valid | input | 1 | One-cycle event: a received character is complete |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | The character has bad parity |
| rx_frm_err | input | 1 | The character has a bad stop bit |
| rx_break | input | 1 | The event is a break condition |
| host_rd_buf | input | 1 | Host reads the receive buffer (pops the head) |
| host_rd_lsr | input | 1 | Host reads the status word |
| host_rd_iir_thre | input | 1 | Host reads interrupt identification while transmit-empty is the reported source |
| tx_load | input | 1 | Host writes a byte for transmission |
| tx_to_shift | input | 1 | One byte moves to the transmit shift register |
| tx_shift_idle | input | 1 | The transmit shift register is empty |
| lsr | output | 8 | Line status byte |
| rx_head_data | output | 8 | Oldest stored received character (0 when empty) |
| rls_irq | output | 1 | Line-status interrupt request |
| thre_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest state to reach is a queued-mode overrun. The queue must be filled to exactly `RX_DEPTH` entries with no read in between, and one more character must then arrive. The bench does this with a loop of distinct bytes, then drains the queue and compares every byte, so a dropped or overwritten entry shows up. Head-tracking of error flags is also tested: a flagged character is placed behind a clean one and advanced to the head with buffer reads. A set event is also placed in the same cycle as a status read.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_flags_t;
endpackage

// File: rtl/uart_lsr_rxq.sv
module uart_lsr_rxq
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_mode,
  input  logic      rx_valid,
  input  logic [7:0] rx_data,
  input  rx_flags_t rx_flags,
  input  logic      rd_buf,
  input  logic      rd_lsr,
  output logic [7:0] head_data,
  output logic      data_ready,
  output logic      overrun,
  output logic      par_err,
  output logic      frm_err,
  output logic      brk_det,
  output logic      fifo_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [7:0] dmem [DEPTH];
  rx_flags_t  fmem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, waddr;
  logic [CW-1:0] cnt, cnt_n, err_cnt, err_n;
  rx_flags_t sticky_q, sticky_n, head_flags, new_flags;
  logic [7:0] in_data;
  logic oe_q, oe_n;
  logic pop, full_fifo, overwrite, store, append, overrun_evt, head_chg;
  logic in_any, head_any;

  always_comb begin
    pop         = rd_buf && (cnt != '0);
    in_data     = rx_flags.brk ? 8'h00 : rx_data;
    full_fifo   = (cnt == CW'(DEPTH));
    overwrite   = rx_valid && !fifo_mode && (cnt != '0) && !pop;
    store       = rx_valid && (!fifo_mode || !full_fifo || pop);
    append      = store && !overwrite;
    overrun_evt = fifo_mode ? (rx_valid && full_fifo && !pop) : overwrite;
    waddr       = overwrite ? rd_ptr : wr_ptr;
    head_flags  = fmem[rd_ptr];
    in_any      = |rx_flags;
    head_any    = |head_flags;

    head_chg  = 1'b0;
    new_flags = '0;
    if (pop) begin
      head_chg = 1'b1;
      if (cnt > CW'(1)) new_flags = fmem[ptr_inc(rd_ptr)];
      else if (append)  new_flags = rx_flags;
    end else if (append && (cnt == '0)) begin
      head_chg  = 1'b1;
      new_flags = rx_flags;
    end

    sticky_n = rd_lsr ? '0 : sticky_q;
    if (fifo_mode) begin
      if (head_chg) sticky_n = new_flags;
    end else if (store) begin
      sticky_n = sticky_n | rx_flags;
    end

    oe_n  = (rd_lsr ? 1'b0 : oe_q) | overrun_evt;
    cnt_n = cnt + CW'(append) - CW'(pop);
    err_n = err_cnt + CW'(store && in_any) - CW'((pop || overwrite) && head_any);
  end

  always_ff @(posedge clk) begin
    if (store) begin
      dmem[waddr] <= in_data;
      fmem[waddr] <= rx_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
      err_cnt  <= '0;
      sticky_q <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (pop)    rd_ptr <= ptr_inc(rd_ptr);
      if (append) wr_ptr <= ptr_inc(wr_ptr);
      cnt      <= cnt_n;
      err_cnt  <= err_n;
      sticky_q <= sticky_n;
      oe_q     <= oe_n;
    end
  end

  assign head_data  = (cnt != '0) ? dmem[rd_ptr] : 8'h00;
  assign data_ready = (cnt != '0);
  assign overrun    = oe_q;
  assign par_err    = sticky_q.pe;
  assign frm_err    = sticky_q.fe;
  assign brk_det    = sticky_q.brk;
  assign fifo_err   = fifo_mode && (err_cnt != '0);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && rx_valid && (cnt == CW'(DEPTH)) && !rd_buf)
      |=> ((cnt == CW'(DEPTH)) && overrun));

  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !rx_valid && !rd_buf) |=> (!overrun && !par_err && !frm_err && !brk_det));

  assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && rd_buf && (cnt > CW'(1))) |=> data_ready);

  assert_err_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= cnt);
endmodule

// File: rtl/uart_lsr_tx.sv
module uart_lsr_tx #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic wr,
  input  logic to_shift,
  input  logic shift_idle,
  input  logic ier_en,
  input  logic rd_iir_thre,
  output logic thre,
  output logic temt,
  output logic thre_irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt, cnt_n, limit;
  logic accept, take, rise, en_q, en_rise, pend_q, pend_n;

  always_comb begin
    limit   = fifo_mode ? CW'(DEPTH) : CW'(1);
    accept  = wr && (cnt < limit);
    take    = to_shift && (cnt != '0);
    cnt_n   = cnt + CW'(accept) - CW'(take);
    rise    = (cnt != '0) && (cnt_n == '0);
    en_rise = ier_en && !en_q;
    pend_n  = pend_q;
    if (rd_iir_thre || wr) pend_n = 1'b0;
    if (rise || (en_rise && cnt == '0)) pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      en_q   <= ier_en;
      pend_q <= pend_n;
    end
  end

  assign thre     = (cnt == '0);
  assign temt     = thre && shift_idle;
  assign thre_irq = ier_en && pend_q && thre;

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !to_shift) |=> $stable(cnt));

  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir_thre && !to_shift && !en_rise) |=> !thre_irq);

  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !to_shift) |=> !thre);
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
  import uart_lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       ier_rls_en,
  input  logic       ier_thre_en,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_par_err,
  input  logic       rx_frm_err,
  input  logic       rx_break,
  input  logic       host_rd_buf,
  input  logic       host_rd_lsr,
  input  logic       host_rd_iir_thre,
  input  logic       tx_load,
  input  logic       tx_to_shift,
  input  logic       tx_shift_idle,
  output logic [7:0] lsr,
  output logic [7:0] rx_head_data,
  output logic       rls_irq,
  output logic       thre_irq
);
  rx_flags_t in_flags;
  logic dr, oe, pe, fe, bi, ferr, thre, temt;

  assign in_flags = '{brk: rx_break, fe: rx_frm_err, pe: rx_par_err};

  uart_lsr_rxq #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_flags(in_flags),
    .rd_buf(host_rd_buf), .rd_lsr(host_rd_lsr),
    .head_data(rx_head_data), .data_ready(dr), .overrun(oe),
    .par_err(pe), .frm_err(fe), .brk_det(bi), .fifo_err(ferr)
  );

  uart_lsr_tx #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .wr(tx_load), .to_shift(tx_to_shift), .shift_idle(tx_shift_idle),
    .ier_en(ier_thre_en), .rd_iir_thre(host_rd_iir_thre),
    .thre(thre), .temt(temt), .thre_irq(thre_irq)
  );

  assign lsr     = {ferr, temt, thre, bi, fe, pe, oe, dr};
  assign rls_irq = ier_rls_en && (oe || pe || fe || bi);

  assert_ferr_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !lsr[7]);
endmodule

// File: tb/uart_lsr_tracker_bench.sv
module uart_lsr_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 0, ier_rls_en = 0, ier_thre_en = 0;
  logic rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, rx_break = 0;
  logic [7:0] rx_data = '0;
  logic host_rd_buf = 0, host_rd_lsr = 0, host_rd_iir_thre = 0;
  logic tx_load = 0, tx_to_shift = 0, tx_shift_idle = 1;
  logic [7:0] lsr, rx_head_data;
  logic rls_irq, thre_irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_lsr_tracker u_uart_lsr_tracker (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ier_rls_en(ier_rls_en),
    .ier_thre_en(ier_thre_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break),
    .host_rd_buf(host_rd_buf), .host_rd_lsr(host_rd_lsr),
    .host_rd_iir_thre(host_rd_iir_thre), .tx_load(tx_load),
    .tx_to_shift(tx_to_shift), .tx_shift_idle(tx_shift_idle),
    .lsr(lsr), .rx_head_data(rx_head_data), .rls_irq(rls_irq), .thre_irq(thre_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    rx_valid = 1; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_break = b;
    @(negedge clk);
    rx_valid = 0; rx_par_err = 0; rx_frm_err = 0; rx_break = 0;
  endtask

  task automatic rd_buf();
    host_rd_buf = 1; @(negedge clk); host_rd_buf = 0;
  endtask

  task automatic rd_lsr();
    host_rd_lsr = 1; @(negedge clk); host_rd_lsr = 0;
  endtask

  task automatic t_reset();
    chk("R1 lsr", lsr, 8'h60);
    chk("R1 rls_irq", rls_irq, 0);
    chk("R1 thre_irq", thre_irq, 0);
  endtask

  task automatic t_single();
    fifo_mode = 0; ier_rls_en = 1;
    push(8'h41, 0, 0, 0);
    chk("R2 dr set", lsr[0], 1);
    chk("R2 head", rx_head_data, 8'h41);
    chk("R11 no err irq", rls_irq, 0);
    push(8'h42, 0, 0, 0);
    chk("R3 overrun", lsr[1], 1);
    chk("R3 head replaced", rx_head_data, 8'h42);
    chk("R11 irq", rls_irq, 1);
    rd_lsr();
    chk("R5 clear", lsr[4:1], 0);
    chk("R11 irq drop", rls_irq, 0);
    chk("R2 dr after lsr", lsr[0], 1);
    rd_buf();
    chk("R2 dr clear", lsr[0], 0);
    push(8'h55, 1, 0, 0);
    chk("R5 pe set", lsr[2], 1);
    chk("R10 single mode bit7", lsr[7], 0);
    rd_lsr();
    rd_buf();
    host_rd_lsr = 1;
    push(8'h66, 0, 1, 0);
    host_rd_lsr = 0;
    chk("R5 set wins", lsr[3], 1);
    ier_rls_en = 0;
    @(negedge clk);
    chk("R11 disabled", rls_irq, 0);
    rd_lsr();
    rd_buf();
    chk("R5 cleared", lsr[4:0], 0);
  endtask

  task automatic t_queue_flags();
    fifo_mode = 1;
    push(8'h10, 0, 0, 0);
    push(8'h11, 1, 0, 0);
    push(8'h12, 0, 0, 0);
    chk("R6 clean head", lsr[2], 0);
    chk("R10 flagged stored", lsr[7], 1);
    rd_buf();
    chk("R6 flagged head", lsr[2], 1);
    chk("R6 head data", rx_head_data, 8'h11);
    chk("R2 dr held", lsr[0], 1);
    rd_lsr();
    chk("R5 pe cleared", lsr[2], 0);
    chk("R10 bit7 kept", lsr[7], 1);
    rd_buf();
    chk("R10 bit7 gone", lsr[7], 0);
    chk("R6 head 0x12", rx_head_data, 8'h12);
    rd_buf();
    chk("R2 dr empty", lsr[0], 0);
  endtask

  task automatic t_break();
    push(8'hA5, 0, 0, 1);
    chk("R7 zero char", rx_head_data, 8'h00);
    chk("R7 bit4", lsr[4], 1);
    rd_lsr();
    rd_buf();
    chk("R7 one entry", lsr[0], 0);
    chk("R10 bit7 after pop", lsr[7], 0);
  endtask

  task automatic t_overrun_queue();
    for (int i = 0; i < DEPTH; i++) push(8'h20 + 8'(i), 0, 0, 0);
    chk("R4 no overrun at full", lsr[1], 0);
    push(8'h99, 0, 0, 0);
    chk("R4 overrun", lsr[1], 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4 kept data", rx_head_data, 8'h20 + 8'(i));
      rd_buf();
    end
    chk("R4 dropped", lsr[0], 0);
    rd_lsr();
  endtask

  task automatic t_tx();
    fifo_mode = 0; tx_shift_idle = 1; ier_thre_en = 1;
    @(negedge clk);
    chk("R12 enable pend", thre_irq, 1);
    tx_load = 1; @(negedge clk); tx_load = 0;
    chk("R8 thre clear", lsr[5], 0);
    chk("R9 temt clear", lsr[6], 0);
    chk("R12 load clears", thre_irq, 0);
    rd_lsr();
    chk("R8 lsr read keeps", lsr[5], 0);
    tx_to_shift = 1; tx_shift_idle = 0; @(negedge clk); tx_to_shift = 0;
    chk("R8 thre set", lsr[5], 1);
    chk("R9 temt busy", lsr[6], 0);
    chk("R12 irq on rise", thre_irq, 1);
    tx_shift_idle = 1; #1;
    chk("R9 temt idle", lsr[6], 1);
    @(negedge clk);
    host_rd_iir_thre = 1; @(negedge clk); host_rd_iir_thre = 0;
    chk("R12 iir clears", thre_irq, 0);
    chk("R8 thre kept", lsr[5], 1);
    fifo_mode = 1;
    for (int i = 0; i < 3; i++) begin tx_load = 1; @(negedge clk); end
    tx_load = 0;
    tx_to_shift = 1; @(negedge clk); @(negedge clk); tx_to_shift = 0;
    chk("R8 queued not empty", lsr[5], 0);
    tx_to_shift = 1; @(negedge clk); tx_to_shift = 0;
    chk("R8 queued empty", lsr[5], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_queue_flags();
    t_break();
    t_overrun_queue();
    t_tx();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule